// File: doc/BRIEF.md
# Memory Test Pattern Generator

This block drives the data side of a memory built-in self-test. It produces a stream of 32-bit expected words from one of six selectable patterns, and it grades the words read back from the memory against that stream. The six patterns are:

- an incrementing count;
- a pseudo-random sequence from a maximal-length LFSR;
- a walking one;
- a walking zero;
- an all-ones/all-zeros swing;
- a 0x55555555/0xAAAAAAAA checkerboard.

Together they cover simple debugging, full bit-combination coverage, crosstalk between neighbouring lines, stuck bits and worst-case simultaneous switching.

A test controller pulses `start_i` with a pattern code on `sel_i`. This reloads the pattern and clears the error state. The controller then pulses `adv_i` once per word it writes. To check the memory, the controller pulses `start_i` again with the same code, which replays the identical sequence. On each word it reads back, it presents the data on `rd_data_i` with `cmp_i`.

The block reports four results:

- a registered per-compare mismatch flag;
- a saturating mismatch count;
- a sticky mask of every data bit that has ever failed;
- the word index of the first failure.

Top module: `mem_pattern_gen`

## Requirements
- R1: Out of reset, and in the cycle after `start_i` is high on a clock edge, the word index, mismatch flag, mismatch count, failing-bit mask and first-fail index are all zero. A start latches the pattern code from `sel_i` and loads that pattern's first word onto `exp_o`. `adv_i` and `cmp_i` in the same cycle as `start_i` are ignored. Changing `sel_i` without a start has no effect. After reset the pattern is the incrementing count, starting at 0.
- R2: Code 0 (incrementing): the first word is 0, and each step adds 1 modulo 2^32.
- R3: Code 1 (PRBS): the first word is 0x00000001. Each step shifts the word right by one. If the bit shifted out was 1, the result is XORed with 0x80200003. The word is never zero.
- R4: Code 2 (walking one): the first word is 0x00000001. Each step rotates the word left by one, so the set bit moves from bit 0 to bit 31 and then wraps back to bit 0.
- R5: Code 3 (walking zero): the first word is 0xFFFFFFFE. Each step rotates the word left by one, so exactly one bit is clear.
- R6: Code 4 (swing): the first word is 0xFFFFFFFF. Each step inverts the word.
- R7: Code 5 (checkerboard): the first word is 0x55555555. Each step inverts the word.
- R8: Codes 6 and 7 behave as code 0.
- R9: Each clock edge with `adv_i` high and `start_i` low moves the pattern one step and increments the word index. Without `adv_i`, `exp_o` holds its value.
- R10: `miscmp_o` is high in the cycle after an edge where `cmp_i` was high and `rd_data_i` differed from `exp_o`. Otherwise it is low.
- R11: On each compare, `fail_mask_o` ORs in `rd_data_i ^ exp_o`. Bits stay set until the next start.
- R12: Each mismatching compare increments `err_cnt_o`. The count holds at 2^CNT_W-1 instead of wrapping.
- R13: `first_fail_idx_o` takes the word index of the first mismatching compare after a start. It holds that value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Restart the selected pattern and clear the results |
| sel_i | input | 3 | Pattern code, latched on start |
| adv_i | input | 1 | Step to the next word |
| cmp_i | input | 1 | Compare `rd_data_i` with `exp_o` |
| rd_data_i | input | DATA_W | Word read back from memory |
| exp_o | output | DATA_W | Current expected word |
| miscmp_o | output | 1 | Last compare mismatched |
| err_cnt_o | output | CNT_W | Saturating mismatch count |
| fail_mask_o | output | DATA_W | Sticky mask of failing bits |
| first_fail_idx_o | output | IDX_W | Word index of the first mismatch |

## Verification
Any fault in the shared pattern register appears on `exp_o` in the cycle after the step that caused it. Because every later word derives from the current one, the fault then persists for the rest of the pass. A wrong seed or mode decode shows in the first word after a start. Faults in the error accumulator appear one cycle after the offending compare, on the count, the mask or the first-fail index. A missed clear on start appears in the cycle directly after the start.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  typedef enum logic [2:0] {
    PAT_INCR    = 3'd0,
    PAT_PRBS    = 3'd1,
    PAT_WALK1   = 3'd2,
    PAT_WALK0   = 3'd3,
    PAT_SWING   = 3'd4,
    PAT_CHECKER = 3'd5
  } pat_e;
endpackage

// File: rtl/mpg_lfsr.sv
module mpg_lfsr #(
  parameter int unsigned       W    = 32,
  parameter logic [W-1:0]      POLY = 32'h8020_0003
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  // Galois form, right shift
  always_comb begin
    nxt_o = cur_i >> 1;
    if (cur_i[0]) nxt_o = nxt_o ^ POLY;
  end
endmodule

// File: rtl/mpg_word_gen.sv
module mpg_word_gen
  import mpg_pkg::*;
#(
  parameter int unsigned           DATA_W = 32,
  parameter logic [DATA_W-1:0]     SEED   = 1,
  parameter logic [DATA_W-1:0]     POLY   = 32'h8020_0003
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        sel_i,
  input  logic              adv_i,
  output logic [DATA_W-1:0] word_o
);
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ALT  = {(DATA_W/2){2'b01}};

  pat_e              mode_q, mode_d;
  logic [DATA_W-1:0] state_q, state_d, first_w, step_w, lfsr_nxt;

  mpg_lfsr #(.W(DATA_W), .POLY(POLY)) i_lfsr (.cur_i(state_q), .nxt_o(lfsr_nxt));

  always_comb mode_d = (sel_i > 3'd5) ? PAT_INCR : pat_e'(sel_i);

  always_comb begin
    case (mode_d)
      PAT_PRBS:    first_w = SEED;
      PAT_WALK1:   first_w = {{(DATA_W-1){1'b0}}, 1'b1};
      PAT_WALK0:   first_w = ~{{(DATA_W-1){1'b0}}, 1'b1};
      PAT_SWING:   first_w = ONES;
      PAT_CHECKER: first_w = ALT;
      default:     first_w = '0;
    endcase
  end

  always_comb begin
    case (mode_q)
      PAT_PRBS:                step_w = lfsr_nxt;
      PAT_WALK1, PAT_WALK0:    step_w = {state_q[DATA_W-2:0], state_q[DATA_W-1]};
      PAT_SWING, PAT_CHECKER:  step_w = ~state_q;
      default:                 step_w = state_q + 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (start_i)    state_d = first_w;
    else if (adv_i) state_d = step_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= PAT_INCR;
      state_q <= '0;
    end else begin
      if (start_i) mode_q <= mode_d;
      state_q <= state_d;
    end
  end

  assign word_o = state_q;

  AST_PRBS_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PAT_PRBS) |-> (state_q != '0));                              // R3
  AST_WALK1_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PAT_WALK1) |-> ($countones(state_q) == 1));                  // R4
  AST_WALK0_ONECOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PAT_WALK0) |-> ($countones(~state_q) == 1));                 // R5
  AST_SWING_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PAT_SWING && adv_i && !start_i) |=> (state_q == ~$past(state_q))); // R6
  AST_HOLD_NO_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !start_i) |=> $stable(state_q));                             // R9
endmodule

// File: rtl/mpg_err_acc.sv
module mpg_err_acc #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic              cmp_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] rd_i,
  output logic              miscmp_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [IDX_W-1:0]  first_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W-1:0] diff;
  logic              bad;
  logic [IDX_W-1:0]  idx_q, first_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              mis_q;

  assign diff = exp_i ^ rd_i;
  assign bad  = cmp_i && (diff != '0);

  // per-bit sticky fail flags
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  bit_q <= 1'b0;
      else if (start_i)             bit_q <= 1'b0;
      else if (cmp_i && diff[b])    bit_q <= 1'b1;
    end
    assign mask_o[b] = bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      first_q <= '0;
      cnt_q   <= '0;
      mis_q   <= 1'b0;
    end else if (start_i) begin
      idx_q   <= '0;
      first_q <= '0;
      cnt_q   <= '0;
      mis_q   <= 1'b0;
    end else begin
      mis_q <= bad;
      if (adv_i) idx_q <= idx_q + 1'b1;
      if (bad) begin
        if (cnt_q == '0)     first_q <= idx_q;
        if (cnt_q != CNT_MAX) cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign miscmp_o = mis_q;
  assign cnt_o    = cnt_q;
  assign first_o  = first_q;

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == '0 && idx_q == '0 && mask_o == '0 && !mis_q));    // R1
  AST_NO_CMP_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_i |=> !mis_q);                                                     // R10
  AST_MASK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ((mask_o & $past(mask_o)) == $past(mask_o)));              // R11
  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !start_i) |=> (cnt_q == CNT_MAX));                 // R12
  AST_FIRST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !start_i) |=> $stable(first_q));                        // R13
endmodule

// File: rtl/mem_pattern_gen.sv
module mem_pattern_gen #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        sel_i,
  input  logic              adv_i,
  input  logic              cmp_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] exp_o,
  output logic              miscmp_o,
  output logic [CNT_W-1:0]  err_cnt_o,
  output logic [DATA_W-1:0] fail_mask_o,
  output logic [IDX_W-1:0]  first_fail_idx_o
);
  localparam logic [DATA_W-1:0] SEED = 1;
  localparam logic [DATA_W-1:0] POLY = 32'h8020_0003;

  logic [DATA_W-1:0] word;

  mpg_word_gen #(.DATA_W(DATA_W), .SEED(SEED), .POLY(POLY)) i_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .sel_i(sel_i),
    .adv_i(adv_i), .word_o(word)
  );

  mpg_err_acc #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .adv_i(adv_i),
    .cmp_i(cmp_i), .exp_i(word), .rd_i(rd_data_i), .miscmp_o(miscmp_o),
    .cnt_o(err_cnt_o), .mask_o(fail_mask_o), .first_o(first_fail_idx_o)
  );

  assign exp_o = word;
endmodule

// File: tb/test_mem_pattern_gen.sv
module test_mem_pattern_gen;
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, adv_i = 1'b0, cmp_i = 1'b0;
  logic [2:0]  sel_i = '0;
  logic [31:0] rd_data_i = '0;
  logic [31:0] exp_o, fail_mask_o;
  logic        miscmp_o;
  logic [CNT_W-1:0] err_cnt_o;
  logic [15:0] first_fail_idx_o;

  mem_pattern_gen #(.DATA_W(32), .IDX_W(16), .CNT_W(CNT_W)) i_mem_pattern_gen (
    .clk_i, .rst_ni, .start_i, .sel_i, .adv_i, .cmp_i, .rd_data_i,
    .exp_o, .miscmp_o, .err_cnt_o, .fail_mask_o, .first_fail_idx_o
  );

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int          m_mode;
  logic [31:0] m_state, m_mask;
  logic [15:0] m_idx, m_first;
  logic [CNT_W-1:0] m_cnt;
  logic        m_mis;

  function automatic logic [31:0] first_of(int md);
    case (md)
      1: return 32'h0000_0001;
      2: return 32'h0000_0001;
      3: return 32'hFFFF_FFFE;
      4: return 32'hFFFF_FFFF;
      5: return 32'h5555_5555;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] step_of(int md, logic [31:0] s);
    logic [31:0] r;
    case (md)
      1: begin r = s >> 1; if (s[0]) r = r ^ 32'h8020_0003; return r; end
      2, 3: return {s[30:0], s[31]};
      4, 5: return ~s;
      default: return s + 32'd1;
    endcase
  endfunction

  function automatic string tag_of(int md);
    case (md)
      1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; default: return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic check_all(string etag);
    check(etag, exp_o, m_state);
    check("R10", {31'b0, miscmp_o}, {31'b0, m_mis});
    check("R12", {{(32-CNT_W){1'b0}}, err_cnt_o}, {{(32-CNT_W){1'b0}}, m_cnt});
    check("R11", fail_mask_o, m_mask);
    check("R13", {16'b0, first_fail_idx_o}, {16'b0, m_first});
  endtask

  // called just after a falling edge
  task automatic tick(bit st, logic [2:0] s, bit a, bit c, logic [31:0] rd, string etag);
    start_i = st; sel_i = s; adv_i = a; cmp_i = c; rd_data_i = rd;
    if (st) begin
      m_mode = (s > 3'd5) ? 0 : int'(s);
      m_state = first_of(m_mode);
      m_idx = '0; m_cnt = '0; m_mask = '0; m_first = '0; m_mis = 1'b0;
    end else begin
      m_mis = c && (rd != m_state);
      if (c) m_mask = m_mask | (rd ^ m_state);
      if (m_mis) begin
        if (m_cnt == '0) m_first = m_idx;
        if (m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
      end
      if (a) begin m_state = step_of(m_mode, m_state); m_idx = m_idx + 1'b1; end
    end
    @(posedge clk_i); @(negedge clk_i);
    check_all(etag);
  endtask

  function automatic logic [31:0] rd_pick(bit flip);
    logic [31:0] r;
    r = m_state;
    if (flip) r[$urandom_range(31, 0)] ^= 1'b1;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_mode = 0; m_state = '0; m_mask = '0; m_idx = '0; m_first = '0;
    m_cnt = '0; m_mis = 1'b0;
    #20; @(negedge clk_i);
    check_all("R1");                       // reset state
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1");
    // R9: idle hold and stepping in the reset-state incrementing pattern
    tick(0, 3'd5, 0, 0, '0, "R9");         // sel change without start ignored
    tick(0, 3'd5, 1, 0, '0, "R9");
    tick(0, 3'd0, 1, 0, '0, "R9");

    // directed wrap: walking one / walking zero over 35 steps
    for (int p = 2; p <= 3; p++) begin
      tick(1, 3'(p), 0, 0, '0, "R1");
      for (int k = 0; k < 35; k++) tick(0, 3'(p), 1, 0, '0, tag_of(p));
    end

    // random passes over every code, including 6 and 7 (R8)
    for (int p = 0; p < 8; p++) begin
      string t;
      t = (p > 5) ? "R8" : tag_of(p);
      tick(1, 3'(p), 0, 0, '0, "R1");
      for (int k = 0; k < 60; k++) begin
        bit a, c, f;
        a = ($urandom_range(3, 0) != 0);
        c = $urandom_range(1, 0);
        f = ($urandom_range(7, 0) == 0);
        tick(0, 3'(p), a, c, rd_pick(f), t);
      end
    end

    // R1: compare and advance during start are ignored
    tick(1, 3'd1, 1, 1, 32'hDEAD_BEEF, "R1");
    // R13: first failure at index 3, then later failures keep it
    tick(0, 3'd1, 1, 0, '0, "R3");
    tick(0, 3'd1, 1, 0, '0, "R3");
    tick(0, 3'd1, 1, 0, '0, "R3");
    tick(0, 3'd1, 1, 1, m_state ^ 32'h8000_0001, "R13");
    tick(0, 3'd1, 1, 1, m_state ^ 32'h0000_0100, "R13");
    // R12: saturation with many failing compares
    for (int k = 0; k < 20; k++) tick(0, 3'd1, 1, 1, ~m_state, "R12");
    // R10: good compare clears the flag, mask stays (R11)
    tick(0, 3'd1, 0, 1, m_state, "R10");
    tick(1, 3'd4, 0, 0, '0, "R1");
    tick(0, 3'd4, 1, 1, 32'hFFFF_FFFF, "R6");
    tick(0, 3'd4, 1, 1, 32'h0000_0000, "R6");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule